// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple synchronous request port inside the chip to an external static RAM that has no clock. The memory holds 65,536 words of 4 bits. It is controlled by an active-low chip select and an active-low write strobe, and it reads and writes over one shared bidirectional 4-bit data bus. The requester presents an address, a direction flag and write data for one idle cycle. The controller then runs the whole access from registered outputs. Every width of that access is a whole number of clock periods, taken from parameters, so the memory's minimum pulse, setup and access times are met at the chosen clock.

Reads hold the chip select low with the write strobe high for a programmed number of cycles. At the end of that count the controller samples the bus into a result register. Writes are strobe-controlled. Chip select and write strobe fall together. The controller drives the bus only for the last few cycles of the strobe, so the memory has floated its outputs before then. The bus is released on the same edge that ends the strobe. A fixed idle gap after each write keeps a following read from meeting the controller's driver on the bus. A one-cycle completion pulse ends every access. Only one access runs at a time.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_n is low, and after reset until a request arrives, sram_ce_n and sram_we_n are 1, rsp_ready is 0 and the controller leaves the data bus undriven.
- R2: A read accepted at clock edge k sets sram_ce_n=0 and sram_we_n=1 at edge k. At edge k+RD_CYCLES it stores the bus value into rsp_rdata, which then equals the word last written to that address (0 for a word never written).
- R3: A write accepted at edge k sets sram_ce_n=0 and sram_we_n=0 at edge k. Both stay 0 until edge k+WP_CYCLES, so the strobe is exactly WP_CYCLES clocks wide, and the addressed word receives req_wdata.
- R4: The controller drives the bus only while sram_we_n is 0. It starts at edge k+WP_CYCLES-DS_CYCLES, so write data is stable for DS_CYCLES clocks before the strobe rises, and it stops on the edge that raises sram_we_n.
- R5: rsp_ready is 1 for exactly one clock per accepted access. It rises RD_CYCLES edges after a read is accepted and WP_CYCLES edges after a write is accepted.
- R6: After a write, the controller ignores req_valid for TURN_CYCLES further edges (default 1). A request held high from the completion pulse of a write is therefore accepted one edge later than one held from the completion pulse of a read.
- R7: A request presented while an access or the post-write gap is in progress is ignored. It changes no memory word, does not alter the running access, and produces no extra rsp_ready.
- R8: sram_ce_n returns to 1 (memory in standby) on the same edge that raises rsp_ready, and stays 1 while the controller is idle.
- R9: sram_addr equals the accepted request's address and stays constant for every cycle in which sram_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | DATA_W (4) | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (4) | Read result, valid with rsp_ready after a read |
| sram_addr | output | ADDR_W (16) | Memory address lines |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq | inout | DATA_W (4) | Shared memory data bus |

## Verification
A wrong sequencer state or counter value appears at the memory pins within the access in which it happens. The write strobe comes out one cycle too short or too long. The data-drive window shifts relative to the strobe edge. Or the chip select rises early, which changes the latency to rsp_ready seen at the next completion. A gap state that is skipped or repeated shows up only at the next request held from a write completion, because that request is accepted one edge early or late. A bad result register or a disturbed memory word is seen only when the same address is next read back, which can be many accesses later under random traffic.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2,
      SEQ_TURN  = 2'd3
   } seq_e;

   // width able to hold the largest phase count
   function automatic int phase_cnt_w(input int rd, input int wp, input int tr);
      int m;
      m = rd;
      if (wp > m) m = wp;
      if (tr > m) m = tr;
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction

endpackage

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
module sram_req_latch #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

endmodule

// File: rtl/sram_dq_port.sv
`timescale 1ns/1ps
module sram_dq_port #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_en,
   input  logic              capture,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   // one tri-state driver per bus line
   for (genvar i = 0; i < DATA_W; i++) begin : g_drv
      assign dq[i] = drive_en ? wdata[i] : 1'bz;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= dq;
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYCLES   = 4,
   parameter int WP_CYCLES   = 4,
   parameter int DS_CYCLES   = 2,
   parameter int TURN_CYCLES = 1,
   parameter int CNT_W       = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic accept,
   output logic capture,
   output logic ce_n,
   output logic we_n,
   output logic drive_en,
   output logic done
);

   localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYCLES - 1);
   localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WP_CYCLES - 1);
   localparam logic [CNT_W-1:0] DRV_START = CNT_W'(WP_CYCLES - DS_CYCLES - 1);
   localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'((TURN_CYCLES > 0) ? TURN_CYCLES - 1 : 0);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   seq_e             state;
   seq_e             after_wr;
   logic [CNT_W-1:0] cnt;
   logic             rd_last;
   logic             wr_last;

   // variant: with or without a bus-turnaround phase after writes
   if (TURN_CYCLES > 0) begin : g_turn
      assign after_wr = SEQ_TURN;
   end else begin : g_no_turn
      assign after_wr = SEQ_IDLE;
   end

   always_comb begin
      accept  = (state == SEQ_IDLE) && req_valid;
      rd_last = (state == SEQ_READ) && (cnt == RD_LAST);
      wr_last = (state == SEQ_WRITE) && (cnt == WR_LAST);
      capture = rd_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         cnt      <= '0;
         ce_n     <= 1'b1;
         we_n     <= 1'b1;
         drive_en <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  state <= req_write ? SEQ_WRITE : SEQ_READ;
                  cnt   <= '0;
                  ce_n  <= 1'b0;
                  we_n  <= ~req_write;
               end
            end
            SEQ_READ: begin
               cnt <= cnt + CNT_ONE;
               if (rd_last) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
                  ce_n  <= 1'b1;
                  done  <= 1'b1;
               end
            end
            SEQ_WRITE: begin
               cnt <= cnt + CNT_ONE;
               if (cnt == DRV_START) drive_en <= 1'b1;
               if (wr_last) begin
                  state    <= after_wr;
                  cnt      <= '0;
                  ce_n     <= 1'b1;
                  we_n     <= 1'b1;
                  drive_en <= 1'b0;
                  done     <= 1'b1;
               end
            end
            SEQ_TURN: begin
               cnt <= cnt + CNT_ONE;
               if (cnt == TURN_LAST) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 4,
   parameter int RD_CYCLES   = 4,
   parameter int WP_CYCLES   = 4,
   parameter int DS_CYCLES   = 2,
   parameter int TURN_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int CNT_W = phase_cnt_w(RD_CYCLES, WP_CYCLES, TURN_CYCLES);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: widths must be positive");
   end
   if (RD_CYCLES < 1) begin : g_bad_rd
      $error("sram_async_ctrl: RD_CYCLES must be at least 1");
   end
   if (DS_CYCLES < 1 || DS_CYCLES >= WP_CYCLES) begin : g_bad_ds
      $error("sram_async_ctrl: need 1 <= DS_CYCLES < WP_CYCLES");
   end
   if (TURN_CYCLES < 0) begin : g_bad_turn
      $error("sram_async_ctrl: TURN_CYCLES must not be negative");
   end

   logic              accept;
   logic              capture;
   logic              dq_drive;
   logic [DATA_W-1:0] wdata_q;

   sram_seq_ctrl #(
      .RD_CYCLES  (RD_CYCLES),
      .WP_CYCLES  (WP_CYCLES),
      .DS_CYCLES  (DS_CYCLES),
      .TURN_CYCLES(TURN_CYCLES),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .accept   (accept),
      .capture  (capture),
      .ce_n     (sram_ce_n),
      .we_n     (sram_we_n),
      .drive_en (dq_drive),
      .done     (rsp_ready)
   );

   sram_req_latch #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .addr_in(req_addr),
      .data_in(req_wdata),
      .addr_q (sram_addr),
      .data_q (wdata_q)
   );

   sram_dq_port #(
      .DATA_W(DATA_W)
   ) u_dq (
      .clk     (clk),
      .rst_n   (rst_n),
      .drive_en(dq_drive),
      .capture (capture),
      .wdata   (wdata_q),
      .rdata   (rsp_rdata),
      .dq      (sram_dq)
   );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
   parameter int ADDR_W      = 16,
   parameter int WP_CYCLES   = 4,
   parameter int TURN_CYCLES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              we_n,
   input logic              drive,
   input logic              ready,
   input logic [ADDR_W-1:0] addr
);

   logic [15:0] we_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    we_lo_cnt <= '0;
      else if (we_n) we_lo_cnt <= '0;
      else           we_lo_cnt <= we_lo_cnt + 16'd1;
   end

   // R3: strobe never active without chip select
   a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);

   // R3: strobe width measured by counter
   a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_lo_cnt == 16'(WP_CYCLES)));

   // R4: bus driven only under an active strobe
   a_r4_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (!we_n && !ce_n));

   // R4: bus released with the strobe's rising edge
   a_r4_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !drive);

   // R5: completion is a single-cycle pulse
   a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   // R8: standby together with completion
   a_r8_standby_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> ce_n);

   // R9: address steady while selected
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> $stable(addr));

   if (TURN_CYCLES > 0) begin : g_turn_chk
      // R6: one standby cycle follows every write
      a_r6_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(we_n) |=> ce_n);
   end

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .WP_CYCLES  (WP_CYCLES),
   .TURN_CYCLES(TURN_CYCLES)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .ce_n (sram_ce_n),
   .we_n (sram_we_n),
   .drive(dq_drive),
   .ready(rsp_ready),
   .addr (sram_addr)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

   localparam int RD = 4;
   localparam int WP = 4;
   localparam int DS = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [15:0] req_addr;
   logic [3:0]  req_wdata;
   logic        rsp_ready;
   logic [3:0]  rsp_rdata;
   logic [15:0] sram_addr;
   logic        sram_ce_n;
   logic        sram_we_n;
   wire  [3:0]  sram_dq;

   int tests  = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #2.5 clk = ~clk;

   sram_async_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr),
      .sram_ce_n(sram_ce_n),
      .sram_we_n(sram_we_n),
      .sram_dq  (sram_dq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [3:0] mem    [logic [15:0]];
   logic [3:0] shadow [logic [15:0]];
   logic [3:0] mdl_q;
   logic [3:0] exp_wdata;
   logic [3:0] mdl_last;
   logic [15:0] mdl_waddr;
   int  mdl_lo, mdl_run;
   bit  mdl_in_wr;

   assign sram_dq = (!sram_ce_n && sram_we_n) ? mdl_q : 4'bz;

   function automatic logic [3:0] mem_get(input logic [15:0] a);
      return mem.exists(a) ? mem[a] : 4'h0;
   endfunction

   function automatic logic [3:0] shadow_get(input logic [15:0] a);
      return shadow.exists(a) ? shadow[a] : 4'h0;
   endfunction

   initial begin
      mdl_in_wr = 1'b0; mdl_lo = 0; mdl_run = 0;
      mdl_last = 4'h0; mdl_waddr = 16'h0; mdl_q = 4'h0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_we_n && sram_ce_n)
            check(1'b0, "R3 strobe without select", 0, 1);
         if (!sram_ce_n && !sram_we_n) begin
            if (!mdl_in_wr) begin
               mdl_run = 1;
            end else if (sram_dq == mdl_last) begin
               mdl_run = mdl_run + 1;
            end else begin
               mdl_run = 1;
            end
            mdl_last  = sram_dq;
            mdl_waddr = sram_addr;
            mdl_lo    = mdl_lo + 1;
            mdl_in_wr = 1'b1;
         end else if (mdl_in_wr) begin
            check(mdl_lo == WP, "R3 strobe width", mdl_lo, WP);
            check(mdl_run >= DS, "R4 data setup", mdl_run, DS);
            check(mdl_last == exp_wdata, "R3 written data", mdl_last, exp_wdata);
            mem[mdl_waddr] = mdl_last;
            mdl_in_wr = 1'b0;
            mdl_lo    = 0;
            mdl_run   = 0;
         end
         mdl_q = mem_get(sram_addr);
      end
   end

   // ---------------- access task ----------------
   // called at a falling edge; returns at a falling edge
   task automatic access(input bit w, input logic [15:0] a, input logic [3:0] d,
                         input int skew, input bit tail);
      int lat;
      int exp_lat;
      logic [3:0] exp_rd;
      lat     = 0;
      exp_lat = (w ? WP : RD) + 1 + skew;
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      if (w) exp_wdata = d;
      forever begin
         @(negedge clk);
         lat++;
         if (skew > 0 && lat == 1)
            check(sram_ce_n == 1'b1, "R6 request held in gap", sram_ce_n, 1);
         if (lat == 1 + skew) begin
            check(sram_addr == a, "R9 address", sram_addr, a);
            check(sram_ce_n == 1'b0, w ? "R3 select" : "R2 select", sram_ce_n, 0);
            check(sram_we_n == !w, w ? "R3 strobe low" : "R2 strobe high", sram_we_n, !w);
         end
         if (rsp_ready) break;
         if (lat > 40) break;
      end
      req_valid = 1'b0;
      check(lat == exp_lat, w ? "R5 write latency" : "R2 read latency", lat, exp_lat);
      check(sram_ce_n == 1'b1, "R8 standby at done", sram_ce_n, 1);
      if (!w) begin
         exp_rd = shadow_get(a);
         check(rsp_rdata == exp_rd, "R2 read data", rsp_rdata, exp_rd);
      end else begin
         shadow[a] = d;
      end
      if (tail) begin
         @(negedge clk);
         check(rsp_ready == 1'b0, "R5 single pulse", rsp_ready, 0);
         check(sram_ce_n == 1'b1, "R8 idle standby", sram_ce_n, 1);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         check(1'b0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // ---------------- main ----------------
   logic [15:0] pool [16];

   initial begin
      int unsigned seed_dummy;
      int n;
      logic [3:0] old_v;
      seed_dummy = $urandom(32'd7734);
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; exp_wdata = '0;
      repeat (4) @(negedge clk);
      // R1: reset state
      check(sram_ce_n == 1'b1, "R1 select idle", sram_ce_n, 1);
      check(sram_we_n == 1'b1, "R1 strobe idle", sram_we_n, 1);
      check(rsp_ready == 1'b0, "R1 ready low", rsp_ready, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(sram_ce_n == 1'b1 && sram_we_n == 1'b1, "R1 idle after reset",
            {sram_ce_n, sram_we_n}, 2'b11);

      // directed corners
      access(1'b0, 16'h1234, 4'h0, 0, 1'b1);          // R2 never written -> 0
      access(1'b1, 16'h0000, 4'h5, 0, 1'b1);          // R3 lowest address
      access(1'b1, 16'hFFFF, 4'hA, 0, 1'b1);          // R3 highest address
      access(1'b0, 16'h0000, 4'h0, 0, 1'b1);
      access(1'b0, 16'hFFFF, 4'h0, 0, 1'b1);
      access(1'b1, 16'h00F0, 4'hF, 0, 1'b1);
      access(1'b1, 16'h00F0, 4'h0, 0, 1'b1);          // overwrite with zero
      access(1'b0, 16'h00F0, 4'h0, 0, 1'b1);

      // R6: request held straight from a write completion
      access(1'b1, 16'h0101, 4'h6, 0, 1'b0);
      access(1'b0, 16'h0101, 4'h0, 1, 1'b1);
      // read completion followed at once by a read: no gap
      access(1'b0, 16'h0101, 4'h0, 0, 1'b0);
      access(1'b0, 16'hFFFF, 4'h0, 0, 1'b1);

      // R7: request changes while a read is running
      old_v = shadow_get(16'h0101);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0101; req_wdata = 4'h0;
      n = 0;
      @(negedge clk); n++;
      req_write = 1'b1; req_wdata = ~old_v; req_addr = 16'h0202;
      @(negedge clk); n++;
      @(negedge clk); n++;
      req_valid = 1'b0;
      while (!rsp_ready && n < 40) begin
         @(negedge clk); n++;
      end
      check(n == RD + 1, "R7 running read kept", n, RD + 1);
      check(rsp_rdata == old_v, "R7 read result", rsp_rdata, old_v);
      @(negedge clk);
      check(rsp_ready == 1'b0 && sram_ce_n == 1'b1, "R7 no extra access",
            {rsp_ready, sram_ce_n}, 2'b01);
      access(1'b0, 16'h0101, 4'h0, 0, 1'b1);
      access(1'b0, 16'h0202, 4'h0, 0, 1'b1);

      // constrained random traffic over a small address pool
      for (int i = 0; i < 16; i++) pool[i] = 16'($urandom);
      pool[0] = 16'h0000;
      pool[1] = 16'hFFFF;
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         bit          w;
         bit          t;
         a = pool[$urandom_range(15, 0)];
         w = ($urandom_range(1, 0) == 1);
         t = w ? 1'b1 : ($urandom_range(1, 0) == 1);
         access(w, a, 4'($urandom), 0, t);
      end
      // closing sweep: every pool word read back
      for (int i = 0; i < 16; i++) access(1'b0, pool[i], 4'h0, 0, 1'b1);

      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule